// File: doc/BRIEF.md
# Eight-Input ADC Conversion Controller

This block sits between a simple register bus and a successive-approximation converter with eight multiplexed inputs. Software programs a control/status word (input select, clock divider, reference choice, enable, interrupt enable) and sets a start bit. The block then derives a conversion tick from the system clock, counts out one conversion, captures a 10-bit result into a read-only data word, raises a sticky completion status and, when enabled, an interrupt line.

The analog converter itself lives outside the block. In its place a digital port carries the sample for the selected input; the block drives the input select it latched at start and pulses a capture strobe in the cycle it takes the sample. The reference choice is only stored and read back. A soft-reset bit aborts a conversion without losing the configuration.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset both registers read 0 and `irq_o` is 0.
- R2: The control word at offset 0x0 stores input select in bits 26:24, interrupt enable at bit 21, reference select at bit 19, module enable at bit 17 and the divider in bits 8:1, and reads them back; every other bit written (including 27, 30 and 0) reads back 0, and the reset bit 16 always reads 0.
- R3: A control write with bit 13 (start) and bit 17 (enable) both 1 begins a conversion; bit 13 reads 1 from the cycle after that write for exactly 24*(divider+1) cycles, then reads 0.
- R4: At completion bits 9:0 of the data word at offset 0x4 hold the value of `smp_data_i` in the capture cycle, upper bits 0; `smp_chan_o` shows the input select written with the start.
- R5: Completion sets status bit 18; writing 1 to bit 18 clears it, writing 0 keeps it.
- R6: `irq_o` is 1 exactly when status bit 18 and interrupt enable bit 21 are both 1.
- R7: A start write with bit 17 at 0 begins no conversion.
- R8: Writing 0 to bit 13 has no effect on an idle block, and a start write during a conversion neither restarts nor extends it.
- R9: Writing 1 to bit 16 aborts any conversion, clears bit 18 and the data word, and keeps input select, divider, enable, interrupt enable and reference select; an aborted conversion captures nothing.
- R10: Writes to the data word are ignored.
- R11: `smp_take_o` is high for exactly one cycle per completed conversion, the last cycle of the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 4 | Byte offset: 0x0 control, 0x4 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| smp_data_i | input | 10 | Digital stand-in for the converter output |
| smp_chan_o | output | 3 | Input select latched at start |
| smp_take_o | output | 1 | Capture strobe, high in the cycle the sample is taken |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench counts the busy window to the exact cycle for several divider values, since an off-by-one in the divider or tick counter would stretch or shorten every conversion by a tick. It restarts during a conversion to catch a design that reloads its counters, and it aborts mid-conversion with status already set to catch a design that finishes the aborted conversion later or loses its configuration. It writes junk bits and a start without enable to catch decode that leaks bits or ignores the enable gate, and it clears status by writing it back as one to catch a plain-write status bit.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 4;
    localparam int RES_W      = 10;
    localparam int DIV_W      = 8;
    localparam int CH_W       = 3;
    localparam int CONV_TICKS = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_DATA = 4'h4;

    localparam int B_CH_LO = 24;
    localparam int B_IE    = 21;
    localparam int B_REF   = 19;
    localparam int B_ST    = 18;
    localparam int B_EN    = 17;
    localparam int B_RST   = 16;
    localparam int B_GO    = 13;
    localparam int B_DV_LO = 1;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [CH_W-1:0]  cur_ch;
        logic             ie;
        logic             refsel;
        logic             st;
        logic             en;
        logic [DIV_W-1:0] div;
        logic [RES_W-1:0] data;
    } regs_t;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    // period 2*(div+1): count 0 .. 2*div+1
    assign lim = {div_i, 1'b1};

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == lim) begin
            cnt_d  = '0;
            tick_o = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int CONV_TICKS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    input  logic tick_i,
    output logic busy_o,
    output logic take_o
);
    localparam int TC_W = $clog2(CONV_TICKS);
    localparam logic [TC_W-1:0] LAST = TC_W'(CONV_TICKS - 1);

    typedef struct packed {
        logic            busy;
        logic [TC_W-1:0] tcnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        take_o = 1'b0;
        if (abort_i) begin
            s_d.busy = 1'b0;
            s_d.tcnt = '0;
        end else if (s_q.busy) begin
            if (tick_i) begin
                if (s_q.tcnt == LAST) begin
                    take_o   = 1'b1;
                    s_d.busy = 1'b0;
                    s_d.tcnt = '0;
                end else begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                end
            end
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.tcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !abort_i) |=> busy_o);
    // R11
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (!take_o && !busy_o));
    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !busy_o);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [RES_W-1:0]  smp_data_i,
    output logic [CH_W-1:0]   smp_chan_o,
    output logic              smp_take_o,
    output logic              irq_o
);
    regs_t r_d, r_q;
    logic  wr_ctrl, abort, start_acc, tick, busy, take;

    assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
    assign abort     = wr_ctrl && bus_wdata[B_RST];
    assign start_acc = wr_ctrl && bus_wdata[B_GO] && bus_wdata[B_EN]
                       && !bus_wdata[B_RST] && !busy;

    adc_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .div_i  (r_q.div),
        .tick_o (tick)
    );

    adc_conv_seq #(.CONV_TICKS(CONV_TICKS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_acc),
        .abort_i (abort),
        .tick_i  (tick),
        .busy_o  (busy),
        .take_o  (take)
    );

    always_comb begin
        r_d = r_q;
        if (wr_ctrl && !bus_wdata[B_RST]) begin
            r_d.chan   = bus_wdata[B_CH_LO +: CH_W];
            r_d.ie     = bus_wdata[B_IE];
            r_d.refsel = bus_wdata[B_REF];
            r_d.en     = bus_wdata[B_EN];
            r_d.div    = bus_wdata[B_DV_LO +: DIV_W];
            if (bus_wdata[B_ST]) r_d.st = 1'b0;
        end
        if (start_acc) r_d.cur_ch = bus_wdata[B_CH_LO +: CH_W];
        if (take) begin
            r_d.st   = 1'b1;
            r_d.data = smp_data_i;
        end
        if (abort) begin
            r_d.st   = 1'b0;
            r_d.data = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL) begin
            bus_rdata[B_CH_LO +: CH_W]  = r_q.chan;
            bus_rdata[B_IE]             = r_q.ie;
            bus_rdata[B_REF]            = r_q.refsel;
            bus_rdata[B_ST]             = r_q.st;
            bus_rdata[B_EN]             = r_q.en;
            bus_rdata[B_GO]             = busy;
            bus_rdata[B_DV_LO +: DIV_W] = r_q.div;
        end else if (bus_addr == OFS_DATA) begin
            bus_rdata[RES_W-1:0] = r_q.data;
        end
    end

    assign smp_chan_o = r_q.cur_ch;
    assign smp_take_o = take;
    assign irq_o      = r_q.st && r_q.ie;

    // R5
    st_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> r_q.st);
    // R9
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!r_q.st && r_q.data == '0 && !busy));
    // R7
    no_en_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_ctrl && !bus_wdata[B_EN]) |=> !busy);
    // R6
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (bus_addr != OFS_CTRL || (bus_rdata[B_ST] && bus_rdata[B_IE])));
endmodule

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb;
    typedef struct packed {
        logic [2:0] ch;
        logic [7:0] dv;
        logic [9:0] s;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 8'd0, 10'h000},
        '{3'd7, 8'd1, 10'h3FF},
        '{3'd3, 8'd2, 10'h155},
        '{3'd5, 8'd0, 10'h2AA},
        '{3'd1, 8'd3, 10'h0F0}
    };

    localparam logic [31:0] M_IE = 32'h0020_0000;
    localparam logic [31:0] M_ST = 32'h0004_0000;
    localparam logic [31:0] M_EN = 32'h0002_0000;
    localparam logic [31:0] M_RS = 32'h0001_0000;
    localparam logic [31:0] M_GO = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  smp_data_i = '0;
    logic [2:0]  smp_chan_o;
    logic        smp_take_o;
    logic        irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit fin = 0;

    always #5 clk = ~clk;

    adc_conv_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_data_i(smp_data_i),
        .smp_chan_o(smp_chan_o), .smp_take_o(smp_take_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] cfg(input logic [2:0] ch, input logic [7:0] dv);
        return {5'd0, ch, 24'd0} | M_IE | M_EN | {23'd0, dv, 1'b0};
    endfunction

    initial begin
        logic [31:0] v;
        cyc(2); rst_n = 1'b1; #1;
        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 32'h0);
        rd(4'h4, v); check("R1 data", v, 32'h0);
        check("R1 irq", {31'd0, irq_o}, 32'h0);

        // main vector walk: R3 R4 R5 R6 R11
        for (int i = 0; i < NV; i++) begin
            int len;
            len = 24 * (int'(VEC[i].dv) + 1);
            smp_data_i = VEC[i].s;
            wr(4'h0, cfg(VEC[i].ch, VEC[i].dv) | M_GO);
            cyc(len - 1);
            rd(4'h0, v); check("R3 busy last cycle", {31'd0, v[13]}, 32'h1);
            check("R11 take strobe", {31'd0, smp_take_o}, 32'h1);
            check("R4 channel out", {29'd0, smp_chan_o}, {29'd0, VEC[i].ch});
            cyc(1);
            rd(4'h0, v); check("R3 busy ends", {31'd0, v[13]}, 32'h0);
            check("R5 status set", {31'd0, v[18]}, 32'h1);
            check("R11 take low", {31'd0, smp_take_o}, 32'h0);
            check("R6 irq high", {31'd0, irq_o}, 32'h1);
            rd(4'h4, v); check("R4 result", v, {22'd0, VEC[i].s});
            wr(4'h0, cfg(VEC[i].ch, VEC[i].dv));
            rd(4'h0, v); check("R5 write 0 keeps", {31'd0, v[18]}, 32'h1);
            wr(4'h0, cfg(VEC[i].ch, VEC[i].dv) | M_ST);
            rd(4'h0, v); check("R5 w1c", {31'd0, v[18]}, 32'h0);
            check("R6 irq low", {31'd0, irq_o}, 32'h0);
        end

        // R6 status without interrupt enable
        smp_data_i = 10'h011;
        wr(4'h0, (cfg(3'd2, 8'd0) & ~M_IE) | M_GO);
        cyc(30);
        rd(4'h0, v); check("R6 st w/o ie", {31'd0, v[18]}, 32'h1);
        check("R6 irq masked", {31'd0, irq_o}, 32'h0);
        wr(4'h0, M_ST);

        // R2 field decode, R8 no start bit
        wr(4'h0, 32'h4D2A_014B);
        rd(4'h0, v); check("R2 readback", v, 32'h052A_014A);
        cyc(3);
        rd(4'h0, v); check("R8 no start idle", {31'd0, v[13]}, 32'h0);

        // R7 start without enable
        wr(4'h0, M_GO);
        cyc(2);
        rd(4'h0, v); check("R7 no conversion", v, 32'h0);

        // R8 restart during conversion does not extend
        smp_data_i = 10'h2C3;
        wr(4'h0, cfg(3'd4, 8'd0) | M_GO);
        cyc(9);
        wr(4'h0, cfg(3'd6, 8'd0) | M_GO);
        cyc(13);
        rd(4'h0, v); check("R8 still busy", {31'd0, v[13]}, 32'h1);
        check("R8 channel kept", {29'd0, smp_chan_o}, 32'h4);
        cyc(1);
        rd(4'h0, v); check("R8 ends on time", {31'd0, v[13]}, 32'h0);

        // R10 data write ignored
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); check("R10 data kept", v, 32'h0000_02C3);

        // R9 abort mid-conversion with status already set
        smp_data_i = 10'h1A5;
        wr(4'h0, 32'h0222_2002);
        cyc(10);
        wr(4'h0, M_RS);
        rd(4'h0, v); check("R9 fields kept, st/busy clear", v, 32'h0222_0002);
        rd(4'h4, v); check("R9 data cleared", v, 32'h0);
        check("R9 irq low", {31'd0, irq_o}, 32'h0);
        cyc(80);
        rd(4'h0, v); check("R9 no late finish", {31'd0, v[18]}, 32'h0);
        rd(4'h4, v); check("R9 no late capture", v, 32'h0);
        wr(4'h0, 32'h0222_2002);
        rd(4'h0, v); check("R9 restart after abort", {31'd0, v[13]}, 32'h1);

        fin = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!fin) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule